// File: doc/BRIEF.md
# Power-Management Wake Event Generator

This block keeps the power state of a bus-attached device and decides when the device raises a power-management event (PME). The device has five power states: D0 uninitialized, D0 active, D1, D2 and D3. Two kinds of event can set a sticky PME status flag:

- **Interrupt events.** A 32-bit event vector is qualified by a 32-bit mask vector. Whether the master interrupt enable also takes part depends on a configuration bit. Interrupt events count only while the device is in one of the two D0 states.
- **Card insertion.** A card-insertion pulse counts in any power state, but only when PME is enabled.

The wake output models an open-drain pin. The block produces only a pull-low enable, and it is high exactly when status and enable are both set. Software clears the status with a write-one-to-clear strobe.

The same configuration bit that drops the master enable from the qualification also appears in bit 26 of a read-only identification word. Software can read that bit to learn which qualification rule is active.

Top module: `pm_wake_gen`

## Requirements
- R1: The power state holds one of the codes 0 (D0 uninitialized), 1 (D0 active), 2 (D1), 3 (D2) or 4 (D3). A write strobe with a code of 0 to 4 takes effect at the next clock. A write strobe with a code of 5 to 7 leaves the state unchanged.
- R2: `wake_qual_o` is the OR over all bit positions n of event[n] AND mask[n], further ANDed with (ignore bit OR master enable). While the state is 0 or 1, a high `wake_qual_o` sets the PME status at the next clock.
- R3: With the ignore bit at 1, a matching event and mask bit sets the status even while the master enable is 0.
- R4: With the ignore bit at 0 and the master enable at 0, matching event and mask bits neither raise `wake_qual_o` nor set the status.
- R5: In states 2, 3 and 4, interrupt events do not set the status. Event bits whose mask bit is 0 never set it in any state.
- R6: A card-insertion pulse sets the status at the next clock in any state when the enable (as held before that clock) is 1. The pulse has no effect when the enable is 0.
- R7: The status is sticky. The clear strobe resets it at the next clock. When a set condition is present in the same cycle as the clear strobe, the set wins.
- R8: `pme_pull_o` is 1 exactly when status and enable are both 1. Clearing either one releases it in the cycle after the write.
- R9: Writing a D0 code to the power state does not clear the status.
- R10: `id_word_o` bit 26 equals the ignore bit, written through `cfg_wr_i`. All other bits equal the parameter `ID_VALUE`.
- R11: Reset sets the state to 0 and clears the status, the enable, the ignore bit and `pme_pull_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| irq_event_i | input | 32 | Per-source interrupt event flags |
| irq_mask_i | input | 32 | Per-source interrupt mask bits |
| master_en_i | input | 1 | Master interrupt enable |
| cfg_wr_i | input | 1 | Write strobe for the ignore-master-enable bit |
| cfg_ign_i | input | 1 | Value written to the ignore-master-enable bit |
| en_wr_i | input | 1 | Write strobe for the PME enable |
| en_val_i | input | 1 | Value written to the PME enable |
| sts_clr_i | input | 1 | Write-one-to-clear strobe for the PME status |
| ps_wr_i | input | 1 | Power-state write strobe |
| ps_code_i | input | 3 | Power-state code to write |
| card_ins_i | input | 1 | Card-insertion event pulse |
| ps_o | output | 3 | Current power-state code |
| pme_sts_o | output | 1 | Sticky PME status |
| pme_en_o | output | 1 | PME enable |
| cfg_ign_o | output | 1 | Ignore-master-enable bit |
| wake_qual_o | output | 1 | Qualified interrupt wake request |
| id_word_o | output | 32 | Identification word with bit 26 reflecting the ignore bit |
| pme_pull_o | output | 1 | Open-drain pull-low enable for the wake pin |

## Verification
The bench covers the master enable in both configurations:

- With the ignore bit clear, a design that skipped the master enable would raise status while master enable is low.
- With the ignore bit set, a design that always required the master enable would miss the wake.

It also covers these corners:

- **Low-power interrupts.** Interrupts are driven in D1 to D3. A design that did not gate them by state would set status there.
- **Clear and set together.** The clear strobe is driven in the same cycle as a card insertion. A design with clear priority would drop the event.
- **Invalid codes and D0 writes.** These catch a state register that takes any code, and a D0 write that wrongly clears status.

A behavioural model runs alongside through a long random stretch and compares every output on every clock.

// File: rtl/pm_wake_pkg.sv
`timescale 1ns/1ps
package pm_wake_pkg;
  localparam int unsigned PS_W = 3;

  typedef enum logic [PS_W-1:0] {
    PS_D0_UNINIT = 3'd0,
    PS_D0_ACTIVE = 3'd1,
    PS_D1        = 3'd2,
    PS_D2        = 3'd3,
    PS_D3        = 3'd4
  } pstate_e;

  function automatic logic ps_code_ok(input logic [PS_W-1:0] code);
    return code <= 3'd4;
  endfunction

  function automatic logic ps_in_d0(input pstate_e s);
    return (s == PS_D0_UNINIT) || (s == PS_D0_ACTIVE);
  endfunction
endpackage

// File: rtl/pm_wake_qual.sv
`timescale 1ns/1ps
module pm_wake_qual #(
  parameter int unsigned EVT_W  = 32,
  parameter int unsigned LANE_W = 8
) (
  input  logic [EVT_W-1:0] evt_i,
  input  logic [EVT_W-1:0] mask_i,
  input  logic             master_en_i,
  input  logic             ign_master_i,
  output logic             qual_o
);
  localparam int unsigned NLANE = EVT_W / LANE_W;

  logic [NLANE-1:0] lane_hit;

  // reduce per lane first to keep the OR tree shallow and regular
  for (genvar g = 0; g < NLANE; g++) begin : g_lane
    assign lane_hit[g] = |(evt_i[g*LANE_W +: LANE_W] & mask_i[g*LANE_W +: LANE_W]);
  end

  assign qual_o = (|lane_hit) & (ign_master_i | master_en_i);

  always_comb begin
    assert_qual_needs_hit_R2: assert (!qual_o || ((evt_i & mask_i) != '0));
  end
endmodule

// File: rtl/pm_pstate_reg.sv
`timescale 1ns/1ps
module pm_pstate_reg
  import pm_wake_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            wr_i,
  input  logic [PS_W-1:0] code_i,
  output pstate_e         state_o,
  output logic            in_d0_o
);
  pstate_e state_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      state_q <= PS_D0_UNINIT;
    else if (wr_i && ps_code_ok(code_i)) state_q <= pstate_e'(code_i);
  end

  assign state_o = state_q;
  assign in_d0_o = ps_in_d0(state_q);

  assert_bad_code_hold_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !ps_code_ok(code_i)) |=> $stable(state_o));
  assert_good_code_take_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && ps_code_ok(code_i)) |=> (state_o == pstate_e'($past(code_i))));
  assert_code_range_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ps_code_ok(state_o));
endmodule

// File: rtl/pm_sts_ctrl.sv
`timescale 1ns/1ps
module pm_sts_ctrl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic in_d0_i,
  input  logic qual_i,
  input  logic card_i,
  input  logic en_wr_i,
  input  logic en_val_i,
  input  logic clr_i,
  output logic sts_o,
  output logic en_o,
  output logic oe_o
);
  logic sts_q, en_q;
  logic irq_set, card_set, set_req;

  assign irq_set  = in_d0_i & qual_i;
  assign card_set = card_i & en_q;
  assign set_req  = irq_set | card_set;

  // set beats clear so a wake that lands with the clear write is kept
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      sts_q <= 1'b0;
    else if (set_req) sts_q <= 1'b1;
    else if (clr_i)   sts_q <= 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      en_q <= 1'b0;
    else if (en_wr_i) en_q <= en_val_i;
  end

  assign sts_o = sts_q;
  assign en_o  = en_q;
  assign oe_o  = sts_q & en_q;

  assert_irq_wake_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_d0_i && qual_i) |=> sts_o);
  assert_no_lowpower_irq_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!in_d0_i && !sts_o && !(card_i && en_o)) |=> !sts_o);
  assert_card_wake_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (card_i && en_o) |=> sts_o);
  assert_sticky_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sts_o && !clr_i) |=> sts_o);
  assert_clear_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !(in_d0_i && qual_i) && !(card_i && en_o)) |=> !sts_o);
  assert_release_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_wr_i && !en_val_i) |=> !oe_o);
endmodule

// File: rtl/pm_wake_gen.sv
`timescale 1ns/1ps
module pm_wake_gen
  import pm_wake_pkg::*;
#(
  parameter int unsigned EVT_W    = 32,
  parameter int unsigned LANE_W   = 8,
  parameter int unsigned ID_BIT   = 26,
  parameter logic [31:0] ID_VALUE = 32'h1A2B_0C3D
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [EVT_W-1:0] irq_event_i,
  input  logic [EVT_W-1:0] irq_mask_i,
  input  logic             master_en_i,
  input  logic             cfg_wr_i,
  input  logic             cfg_ign_i,
  input  logic             en_wr_i,
  input  logic             en_val_i,
  input  logic             sts_clr_i,
  input  logic             ps_wr_i,
  input  logic [PS_W-1:0]  ps_code_i,
  input  logic             card_ins_i,
  output logic [PS_W-1:0]  ps_o,
  output logic             pme_sts_o,
  output logic             pme_en_o,
  output logic             cfg_ign_o,
  output logic             wake_qual_o,
  output logic [31:0]      id_word_o,
  output logic             pme_pull_o
);
  logic    ign_q;
  logic    in_d0;
  logic    qual;
  pstate_e state;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       ign_q <= 1'b0;
    else if (cfg_wr_i) ign_q <= cfg_ign_i;
  end

  pm_wake_qual #(.EVT_W(EVT_W), .LANE_W(LANE_W)) u_qual (
    .evt_i        (irq_event_i),
    .mask_i       (irq_mask_i),
    .master_en_i  (master_en_i),
    .ign_master_i (ign_q),
    .qual_o       (qual)
  );

  pm_pstate_reg u_pstate (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (ps_wr_i),
    .code_i  (ps_code_i),
    .state_o (state),
    .in_d0_o (in_d0)
  );

  pm_sts_ctrl u_sts (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .in_d0_i  (in_d0),
    .qual_i   (qual),
    .card_i   (card_ins_i),
    .en_wr_i  (en_wr_i),
    .en_val_i (en_val_i),
    .clr_i    (sts_clr_i),
    .sts_o    (pme_sts_o),
    .en_o     (pme_en_o),
    .oe_o     (pme_pull_o)
  );

  always_comb begin
    id_word_o         = ID_VALUE;
    id_word_o[ID_BIT] = ign_q;
  end

  assign ps_o        = state;
  assign cfg_ign_o   = ign_q;
  assign wake_qual_o = qual;

  assert_id_mirror_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_wr_i |=> (id_word_o[ID_BIT] == $past(cfg_ign_i)));
  assert_d0_write_keeps_sts_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ps_wr_i && ps_code_i <= 3'd1 && pme_sts_o && !sts_clr_i) |=> pme_sts_o);
endmodule

// File: tb/pm_wake_gen_bench.sv
`timescale 1ns/1ps
module pm_wake_gen_bench;
  localparam logic [31:0] IDV = 32'h1A2B_0C3D;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] evt = '0, msk = '0;
  logic        master = 1'b0, cfg_wr = 1'b0, cfg_val = 1'b0;
  logic        en_wr = 1'b0, en_val = 1'b0, clr = 1'b0;
  logic        ps_wr = 1'b0, card = 1'b0;
  logic [2:0]  ps_code = '0;
  logic [2:0]  ps;
  logic        sts, en, ign, qual, pull;
  logic [31:0] id;

  int n_tests = 0, n_fail = 0;
  bit done = 0;

  // reference model state
  int m_st = 0;
  bit m_sts = 0, m_en = 0, m_ign = 0;

  always #2.5 clk = ~clk;

  pm_wake_gen u_pm_wake_gen (
    .clk_i(clk), .rst_ni(rst_n), .irq_event_i(evt), .irq_mask_i(msk),
    .master_en_i(master), .cfg_wr_i(cfg_wr), .cfg_ign_i(cfg_val),
    .en_wr_i(en_wr), .en_val_i(en_val), .sts_clr_i(clr), .ps_wr_i(ps_wr),
    .ps_code_i(ps_code), .card_ins_i(card), .ps_o(ps), .pme_sts_o(sts),
    .pme_en_o(en), .cfg_ign_o(ign), .wake_qual_o(qual), .id_word_o(id),
    .pme_pull_o(pull));

  function automatic bit m_qual();
    return ((evt & msk) != 0) && (m_ign || master);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = 0; m_sts = 0; m_en = 0; m_ign = 0;
    end else begin
      bit set_now;
      set_now = ((m_st <= 1) && m_qual()) || (card && m_en);
      if (set_now) m_sts = 1; else if (clr) m_sts = 0;
      if (en_wr) m_en = en_val;
      if (cfg_wr) m_ign = cfg_val;
      if (ps_wr && ps_code <= 3'd4) m_st = int'(ps_code);
    end
  end

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // per-clock comparison against the model
  always @(negedge clk) if (rst_n && !done) begin
    check("R1 power state", 32'(ps), 32'(m_st));
    check("R7 status", 32'(sts), 32'(m_sts));
    check("R8 pull", 32'(pull), 32'(m_sts && m_en));
    check("R10 id word", id, (IDV & ~(32'h1 << 26)) | (32'(m_ign) << 26));
    check("R2 wake_qual", 32'(qual), 32'(m_qual()));
  end

  task automatic cyc();
    @(negedge clk); #1;
  endtask

  task automatic idle();
    cfg_wr = 0; en_wr = 0; clr = 0; ps_wr = 0; card = 0;
  endtask

  initial begin
    #(5.0 * 100000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    check("R11 reset state", 32'(ps), 0);
    check("R11 reset sts", 32'(sts), 0);
    check("R11 reset en/ign/pull", {29'd0, en, ign, pull}, 0);
    rst_n = 1;
    cyc();

    // R2: D0 uninit, master on, matching bit 5
    master = 1; evt = 32'h20; msk = 32'h20; cyc();
    evt = 0; cyc();
    check("R2 irq sets status in D0", 32'(sts), 1);
    clr = 1; cyc(); idle();
    check("R7 clear strobe", 32'(sts), 0);

    // R4: ignore=0, master off
    master = 0; evt = 32'h8000_0000; msk = 32'h8000_0000; #1;
    check("R4 qual blocked by master", 32'(qual), 0);
    cyc(); cyc();
    check("R4 no status without master", 32'(sts), 0);

    // R3 / R10: ignore=1
    evt = 0; cfg_wr = 1; cfg_val = 1; cyc(); idle();
    check("R10 id bit26 set", 32'(id[26]), 1);
    evt = 32'h8000_0000; cyc(); evt = 0; cyc();
    check("R3 wake without master", 32'(sts), 1);
    clr = 1; cyc(); idle();

    // R5: low-power states, and unmasked bits in D0
    evt = 32'h0000_0F00; msk = 32'h0000_00F0; cyc(); cyc();
    check("R5 unmasked bits ignored", 32'(sts), 0);
    ps_wr = 1; ps_code = 3'd2; cyc(); idle();
    evt = 32'hFFFF_FFFF; msk = 32'hFFFF_FFFF; master = 1; cyc(); cyc();
    check("R5 no irq wake in D1", 32'(sts), 0);
    ps_wr = 1; ps_code = 3'd4; cyc(); idle(); cyc();
    check("R5 no irq wake in D3", 32'(sts), 0);
    evt = 0;

    // R6: card insertion
    card = 1; cyc(); idle(); cyc();
    check("R6 card ignored when disabled", 32'(sts), 0);
    en_wr = 1; en_val = 1; cyc(); idle();
    card = 1; cyc(); idle();
    check("R6 card wakes from D3", 32'(sts), 1);
    check("R8 pull asserted", 32'(pull), 1);

    // R9: writing D0 keeps status
    ps_wr = 1; ps_code = 3'd1; cyc(); idle();
    check("R9 D0 write keeps status", 32'(sts), 1);
    check("R1 state D0 active", 32'(ps), 1);

    // R7: set wins over clear
    clr = 1; card = 1; cyc(); idle();
    check("R7 set wins over clear", 32'(sts), 1);
    en_wr = 1; en_val = 0; cyc(); idle();
    check("R8 pull released", 32'(pull), 0);

    // R1: invalid codes
    ps_wr = 1; ps_code = 3'd6; cyc(); idle();
    check("R1 invalid code ignored", 32'(ps), 1);

    // random stretch checked by the model every clock
    for (int i = 0; i < 2000; i++) begin
      evt     = $urandom() & $urandom() & $urandom();
      msk     = $urandom() & $urandom();
      master  = 1'($urandom() & 1);
      cfg_wr  = ($urandom() % 16) == 0;
      cfg_val = 1'($urandom() & 1);
      en_wr   = ($urandom() % 8) == 0;
      en_val  = 1'($urandom() & 1);
      clr     = ($urandom() % 4) == 0;
      ps_wr   = ($urandom() % 6) == 0;
      ps_code = 3'($urandom());
      card    = ($urandom() % 10) == 0;
      cyc();
    end
    idle(); cyc();

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule